// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Walker

This block steers one transmit queue through a chain of descriptors kept in memory. Software places the address of the first descriptor in a head-pointer register and pulses a kick strobe. The walker then reads each descriptor over a single-outstanding request/acknowledge read port. Every descriptor address goes to a downstream frame sender over a valid/ready handshake. After the sender accepts a descriptor, the walker follows that descriptor's link field.

When a descriptor carries a zero link or has its end-of-list flag set, the walk stops. The head pointer is left parked on that last sent descriptor. A later kick does not reload anything from software. It re-reads only the link word of the parked descriptor, so software continues a queue by patching that link in memory.

The head register takes a software write only while it holds zero. A write at any other time is dropped and recorded in a sticky error bit. A queue-stop input aborts the walk, clears the running flag and zeroes the head pointer.

Top module: `txq_desc_walker`

## Requirements
- R1: After reset, `status` is 0 (idle), `head_ptr` is 0, `running`, `drop_err`, `mem_req` and `tx_valid` are all 0.
- R2: A `head_we` write while `head_ptr` is zero loads `head_wdata` into `head_ptr`. A `kick` from idle with a nonzero head pointer starts the walk at that address and sets `running`.
- R3: A descriptor at address A is two 32-bit words. The word at A is the link address and bit 0 of the word at A+4 is the end-of-list flag. They are read in that order, and `mem_req` and `mem_addr` stay steady until `mem_ack`.
- R4: Each fetched descriptor's address is offered on `tx_addr` with `tx_valid`, and both are held unchanged until `tx_ready`.
- R5: The walk ends after the sender accepts a descriptor whose link is zero or whose end-of-list flag is 1. `status` then becomes 3 (stopped), and `head_ptr` holds that last accepted descriptor's address.
- R6: A `kick` in the stopped state reads only the link word of the descriptor at `head_ptr`, ignoring that descriptor's end-of-list flag. The walk continues from the link address that was read.
- R7: If that re-read link is zero, the walker returns to stopped with no descriptor offered and `head_ptr` unchanged.
- R8: A `head_we` write while `head_ptr` is nonzero leaves `head_ptr` unchanged and sets `drop_err`. `drop_err` stays set until reset.
- R9: `running` stays set until stop or reset. A `kick` while idle with a zero head pointer does nothing. A `kick` while running never reloads the walk from a software-written address.
- R10: `q_stop` aborts any fetch or offer at once. On the next cycle `mem_req`, `tx_valid` and `running` are 0, `head_ptr` is 0, `status` is 0, and a following head write is accepted.
- R11: `status` encodes 0 idle, 1 fetching (including the link re-read), 2 offering, 3 stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_stop | input | 1 | Queue shutdown: abort and clear |
| head_we | input | 1 | Software write strobe for the head pointer |
| head_wdata | input | ADDR_W | Head pointer write value |
| kick | input | 1 | Start / restart strobe |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | ADDR_W | Descriptor word address |
| mem_ack | input | 1 | Read completion; data valid |
| mem_rdata | input | DATA_W | Read data |
| tx_valid | output | 1 | Descriptor offered to the frame sender |
| tx_addr | output | ADDR_W | Offered descriptor address |
| tx_ready | input | 1 | Frame sender accepts the offer |
| head_ptr | output | ADDR_W | Head pointer register |
| running | output | 1 | Walk has been started since the last stop |
| status | output | 2 | Walker state code |
| drop_err | output | 1 | Sticky flag for dropped head writes |

## Verification
The assertions assume the memory raises `mem_ack` only while `mem_req` is high and treats a dropped request as cancelled. They also assume the sender may hold `tx_ready` low for any number of cycles. The bench's memory model follows both rules: it answers every request one cycle after seeing it and lowers the acknowledge between words. The bench drives `tx_ready` from a level that the test tasks raise and lower, which lets an offer be stalled for several cycles. Stop pulses and head writes are placed on negative edges, and one stop lands during an open read to exercise the abort path.

// File: rtl/txqw_pkg.sv
package txqw_pkg;
   typedef enum logic [2:0] {
      W_IDLE   = 3'd0,
      W_RELINK = 3'd1,
      W_FETCH  = 3'd2,
      W_ISSUE  = 3'd3,
      W_STOP   = 3'd4
   } walk_st_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_ISSUE = 2'd2,
      ST_STOP  = 2'd3
   } walk_status_t;

   function automatic walk_status_t status_of(walk_st_t s);
      case (s)
         W_RELINK, W_FETCH: return ST_FETCH;
         W_ISSUE:           return ST_ISSUE;
         W_STOP:            return ST_STOP;
         default:           return ST_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/txqw_head_reg.sv
module txqw_head_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              sw_we,
   input  logic [ADDR_W-1:0] sw_wdata,
   output logic [ADDR_W-1:0] hp,
   output logic              err
);
   logic hp_zero;
   logic sw_ok;
   logic sw_drop;

   assign hp_zero = (hp == '0);
   assign sw_ok   = sw_we && hp_zero && !upd && !clr;
   assign sw_drop = sw_we && !sw_ok && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hp  <= '0;
         err <= 1'b0;
      end else begin
         if (clr)        hp <= '0;
         else if (upd)   hp <= upd_addr;
         else if (sw_ok) hp <= sw_wdata;
         if (sw_drop)    err <= 1'b1;
      end
   end

   // R8: a write while nonzero is dropped and flagged
   p_drop_keeps_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !hp_zero && !clr && !upd) |=> (hp == $past(hp)) && err);
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R10: shutdown zeroes the pointer
   p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> hp == '0);
endmodule

// File: rtl/txqw_fetch.sv
module txqw_fetch #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int EOL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              go,
   input  logic              go_link_only,
   input  logic [ADDR_W-1:0] go_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] link,
   output logic              eol
);
   localparam int WORD_BYTES = DATA_W / 8;

   logic              busy_q;
   logic              idx_q;
   logic              one_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] link_w;
   logic              last_word;

   if (ADDR_W == DATA_W) begin : g_link_full
      assign link_w = mem_rdata;
   end else begin : g_link_trunc
      assign link_w = mem_rdata[ADDR_W-1:0];
   end

   assign mem_req   = busy_q;
   assign mem_addr  = base_q + (idx_q ? ADDR_W'(WORD_BYTES) : '0);
   assign last_word = idx_q || one_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= 1'b0;
         one_q  <= 1'b0;
         base_q <= '0;
         done   <= 1'b0;
         link   <= '0;
         eol    <= 1'b0;
      end else if (abort) begin
         busy_q <= 1'b0;
         idx_q  <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            busy_q <= 1'b1;
            idx_q  <= 1'b0;
            one_q  <= go_link_only;
            base_q <= go_addr;
         end else if (busy_q && mem_ack) begin
            if (!idx_q) link <= link_w;
            else        eol  <= mem_rdata[EOL_BIT];
            if (last_word) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end else begin
               idx_q <= 1'b1;
            end
         end
      end
   end

   // R3: request and address held until acknowledged
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !abort) |=> mem_req && $stable(mem_addr));
   // R10: abort cancels the request
   p_abort_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !mem_req && !done);
endmodule

// File: rtl/txq_desc_walker.sv
module txq_desc_walker
   import txqw_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int EOL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_stop,
   input  logic              head_we,
   input  logic [ADDR_W-1:0] head_wdata,
   input  logic              kick,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_ready,
   output logic [ADDR_W-1:0] head_ptr,
   output logic              running,
   output logic [1:0]        status,
   output logic              drop_err
);
   if (DATA_W != 32) begin : g_bad_data
      $error("txq_desc_walker: descriptor words must be 32 bits");
   end
   if (ADDR_W < 4 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("txq_desc_walker: ADDR_W must be in 4..DATA_W");
   end
   if (EOL_BIT < 0 || EOL_BIT >= DATA_W) begin : g_bad_eol
      $error("txq_desc_walker: EOL_BIT out of range");
   end

   walk_st_t          st_q, st_d;
   logic [ADDR_W-1:0] cur_q, cur_d;
   logic              run_q, run_d;
   logic              go, go_one;
   logic [ADDR_W-1:0] go_addr;
   logic              hp_upd;
   logic              f_done, f_eol;
   logic [ADDR_W-1:0] f_link;

   txqw_head_reg #(.ADDR_W(ADDR_W)) u_head (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (q_stop),
      .upd      (hp_upd),
      .upd_addr (cur_q),
      .sw_we    (head_we),
      .sw_wdata (head_wdata),
      .hp       (head_ptr),
      .err      (drop_err)
   );

   txqw_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EOL_BIT(EOL_BIT)) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .abort        (q_stop),
      .go           (go),
      .go_link_only (go_one),
      .go_addr      (go_addr),
      .mem_req      (mem_req),
      .mem_addr     (mem_addr),
      .mem_ack      (mem_ack),
      .mem_rdata    (mem_rdata),
      .done         (f_done),
      .link         (f_link),
      .eol          (f_eol)
   );

   always_comb begin
      st_d    = st_q;
      cur_d   = cur_q;
      run_d   = run_q;
      go      = 1'b0;
      go_one  = 1'b0;
      go_addr = cur_q;
      hp_upd  = 1'b0;
      case (st_q)
         W_IDLE: begin
            if (kick && !run_q && head_ptr != '0) begin
               go      = 1'b1;
               go_addr = head_ptr;
               cur_d   = head_ptr;
               run_d   = 1'b1;
               st_d    = W_FETCH;
            end
         end
         W_STOP: begin
            if (kick) begin
               go      = 1'b1;
               go_one  = 1'b1;
               go_addr = head_ptr;
               st_d    = W_RELINK;
            end
         end
         W_RELINK: begin
            if (f_done) begin
               if (f_link == '0) begin
                  st_d = W_STOP;
               end else begin
                  go      = 1'b1;
                  go_addr = f_link;
                  cur_d   = f_link;
                  st_d    = W_FETCH;
               end
            end
         end
         W_FETCH: begin
            if (f_done) st_d = W_ISSUE;
         end
         W_ISSUE: begin
            if (tx_ready) begin
               hp_upd = 1'b1;
               if (f_link == '0 || f_eol) begin
                  st_d = W_STOP;
               end else begin
                  go      = 1'b1;
                  go_addr = f_link;
                  cur_d   = f_link;
                  st_d    = W_FETCH;
               end
            end
         end
         default: st_d = W_IDLE;
      endcase
      if (q_stop) begin
         st_d   = W_IDLE;
         run_d  = 1'b0;
         go     = 1'b0;
         hp_upd = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= W_IDLE;
         cur_q <= '0;
         run_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cur_q <= cur_d;
         run_q <= run_d;
      end
   end

   assign tx_valid = (st_q == W_ISSUE);
   assign tx_addr  = cur_q;
   assign running  = run_q;
   assign status   = status_of(st_q);

   // R4: offer held until accepted
   p_offer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !q_stop) |=> tx_valid && $stable(tx_addr));
   // R9: running only falls on stop
   p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !q_stop) |=> running);
   // R10: stop leaves everything idle
   p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      q_stop |=> !running && !tx_valid && status == 2'd0);
   // R7: zero re-read link returns to stopped without an offer
   p_relink_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == W_RELINK && f_done && f_link == '0 && !q_stop)
         |=> status == 2'd3 && !tx_valid && $stable(head_ptr));
   // R5: accepting a terminal descriptor parks on it
   p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !q_stop && (f_link == '0 || f_eol))
         |=> status == 2'd3 && head_ptr == $past(tx_addr));
endmodule

// File: tb/txq_desc_walker_test.sv
module txq_desc_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        q_stop = 1'b0;
   logic        head_we = 1'b0;
   logic [31:0] head_wdata = '0;
   logic        kick = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        tx_valid;
   logic [31:0] tx_addr;
   logic        tx_ready = 1'b0;
   logic [31:0] head_ptr;
   logic        running;
   logic [1:0]  status;
   logic        drop_err;

   logic        ready_en = 1'b1;
   logic [31:0] mem [64];
   logic [31:0] rd_log [64];
   logic [31:0] tx_log [64];
   int          n_rd = 0;
   int          n_tx = 0;
   int          n_checks = 0;
   int          n_fail = 0;
   int          cycles = 0;

   always #4 clk = ~clk;

   txq_desc_walker uut (
      .clk(clk), .rst_n(rst_n), .q_stop(q_stop),
      .head_we(head_we), .head_wdata(head_wdata), .kick(kick),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_addr(tx_addr),
      .tx_ready(tx_ready), .head_ptr(head_ptr), .running(running),
      .status(status), .drop_err(drop_err)
   );

   // memory responder and frame sender model
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
      end else if (mem_req && !mem_ack) begin
         mem_ack   = 1'b1;
         mem_rdata = mem[mem_addr[7:2]];
         if (n_rd < 64) rd_log[n_rd] = mem_addr;
         n_rd++;
      end else begin
         mem_ack = 1'b0;
      end
      tx_ready = ready_en;
      if (tx_valid && tx_ready) begin
         if (n_tx < 64) tx_log[n_tx] = tx_addr;
         n_tx++;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements): cycles=%0d expected < 20000", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic set_desc(logic [31:0] a, logic [31:0] lnk, logic eol);
      mem[a[7:2]]       = lnk;
      mem[a[7:2] + 6'd1] = {31'd0, eol};
   endtask

   task automatic pulse_kick();
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); q_stop = 1'b1;
      @(negedge clk); q_stop = 1'b0;
   endtask

   task automatic write_head(logic [31:0] v);
      @(negedge clk); head_we = 1'b1; head_wdata = v;
      @(negedge clk); head_we = 1'b0;
   endtask

   task automatic wait_stopped();
      for (int i = 0; i < 300; i++) begin
         if (status == 2'd3) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R1", "status", 32'(status), 32'd0);
      chk("R1", "head_ptr", head_ptr, 32'd0);
      chk("R1", "running", 32'(running), 32'd0);
      chk("R1", "drop_err", 32'(drop_err), 32'd0);
      chk("R1", "mem_req", 32'(mem_req), 32'd0);
      chk("R1", "tx_valid", 32'(tx_valid), 32'd0);
   endtask

   task automatic t_kick_empty();
      int rd0 = n_rd;
      pulse_kick();
      repeat (3) @(negedge clk);
      chk("R9", "idle kick with zero head: status", 32'(status), 32'd0);
      chk("R9", "idle kick with zero head: running", 32'(running), 32'd0);
      chk("R9", "idle kick with zero head: reads", 32'(n_rd - rd0), 32'd0);
   endtask

   task automatic t_first_walk();
      int rd0 = n_rd;
      int tx0 = n_tx;
      set_desc(32'h40, 32'h50, 1'b0);
      set_desc(32'h50, 32'h60, 1'b0);
      set_desc(32'h60, 32'h0, 1'b1);
      write_head(32'h40);
      chk("R2", "head accepted", head_ptr, 32'h40);
      ready_en = 1'b0;
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      chk("R11", "status fetching", 32'(status), 32'd1);
      chk("R2", "running set", 32'(running), 32'd1);
      for (int i = 0; i < 50; i++) begin
         if (tx_valid) break;
         @(negedge clk);
      end
      chk("R4", "first offer", tx_addr, 32'h40);
      chk("R11", "status offering", 32'(status), 32'd2);
      repeat (3) @(negedge clk);
      chk("R4", "held valid", 32'(tx_valid), 32'd1);
      chk("R4", "held addr", tx_addr, 32'h40);
      ready_en = 1'b1;
      wait_stopped();
      chk("R5", "sent count", 32'(n_tx - tx0), 32'd3);
      chk("R4", "sent[1]", tx_log[tx0 + 1], 32'h50);
      chk("R4", "sent[2]", tx_log[tx0 + 2], 32'h60);
      chk("R3", "read count", 32'(n_rd - rd0), 32'd6);
      chk("R3", "read[0]", rd_log[rd0], 32'h40);
      chk("R3", "read[1]", rd_log[rd0 + 1], 32'h44);
      chk("R3", "read[5]", rd_log[rd0 + 5], 32'h64);
      chk("R5", "parked head", head_ptr, 32'h60);
      chk("R11", "status stopped", 32'(status), 32'd3);
   endtask

   task automatic t_drop_write();
      write_head(32'h100);
      chk("R8", "head unchanged", head_ptr, 32'h60);
      chk("R8", "drop_err set", 32'(drop_err), 32'd1);
   endtask

   task automatic t_relink_zero();
      int rd0 = n_rd;
      int tx0 = n_tx;
      pulse_kick();
      chk("R11", "relink counts as fetching", 32'(status), 32'd1);
      repeat (2) @(negedge clk);
      wait_stopped();
      repeat (2) @(negedge clk);
      chk("R7", "status stopped", 32'(status), 32'd3);
      chk("R7", "no offer", 32'(n_tx - tx0), 32'd0);
      chk("R7", "head unchanged", head_ptr, 32'h60);
      chk("R6", "only link word read", 32'(n_rd - rd0), 32'd1);
      chk("R6", "read of parked link", rd_log[rd0], 32'h60);
   endtask

   task automatic t_relink_follow();
      int rd0 = n_rd;
      int tx0 = n_tx;
      set_desc(32'h70, 32'h0, 1'b0);
      mem[6'h18] = 32'h70;
      pulse_kick();
      repeat (2) @(negedge clk);
      wait_stopped();
      chk("R6", "one frame after restart", 32'(n_tx - tx0), 32'd1);
      chk("R6", "restart follows patched link", tx_log[tx0], 32'h70);
      chk("R9", "no reload from dropped write", rd_log[rd0 + 1], 32'h70);
      chk("R6", "read count", 32'(n_rd - rd0), 32'd3);
      chk("R5", "parked head", head_ptr, 32'h70);
      chk("R9", "still running", 32'(running), 32'd1);
   endtask

   task automatic t_eol_walk();
      int tx0;
      pulse_stop();
      chk("R10", "head zeroed", head_ptr, 32'd0);
      chk("R10", "running cleared", 32'(running), 32'd0);
      chk("R10", "status idle", 32'(status), 32'd0);
      chk("R8", "drop_err sticky", 32'(drop_err), 32'd1);
      set_desc(32'h80, 32'h90, 1'b1);
      set_desc(32'h90, 32'h0, 1'b0);
      write_head(32'h80);
      chk("R10", "write accepted after stop", head_ptr, 32'h80);
      tx0 = n_tx;
      pulse_kick();
      wait_stopped();
      chk("R5", "end-of-list stops walk", 32'(n_tx - tx0), 32'd1);
      chk("R5", "parked on eol descriptor", head_ptr, 32'h80);
   endtask

   task automatic t_abort();
      int rd0;
      pulse_stop();
      set_desc(32'hA0, 32'hB0, 1'b0);
      write_head(32'hA0);
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      chk("R10", "fetch open before stop", 32'(mem_req), 32'd1);
      q_stop = 1'b1;
      @(negedge clk); q_stop = 1'b0;
      chk("R10", "mem_req dropped", 32'(mem_req), 32'd0);
      chk("R10", "tx_valid low", 32'(tx_valid), 32'd0);
      chk("R10", "status idle", 32'(status), 32'd0);
      chk("R10", "head zeroed", head_ptr, 32'd0);
      chk("R10", "running cleared", 32'(running), 32'd0);
      rd0 = n_rd;
      repeat (5) @(negedge clk);
      chk("R10", "no reads after abort", 32'(n_rd - rd0), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_kick_empty();
      t_first_walk();
      t_drop_write();
      t_relink_zero();
      t_relink_follow();
      t_eol_walk();
      t_abort();
      summary();
      $finish;
   end
endmodule